// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Marker-Bit Framing

This block takes an asynchronous serial line and turns each frame into a parallel byte. The line rests high. A frame starts with one low start bit. The data bits follow, least significant first, and a high stop bit ends the frame. A clock enable at sixteen times the bit rate drives all timing. The line is first passed through two flops. The receiver then waits for the line to fall. It checks again half a bit later to reject short glitches, and after that it samples every bit at its centre.

The receiver keeps no bit counter. At the start of each frame a shift register one bit wider than the byte is filled with ones. Every centre sample enters at the top of this register and the contents move down by one place. The low start sample is the first to enter. When that zero reaches bit 0, the register's upper bits hold the whole byte. The next centre sample is then the stop bit. At that point the byte is presented with a one-cycle strobe, and a framing flag is raised if the stop sample is low. A four-bit phase count only marks the sixteen ticks within a bit.

Top module: `serial_rx_marker`

## Requirements
- R1: A synchronous active-high reset clears the output byte to 0x00, clears the strobe and the framing flag, and returns the receiver to idle. This also applies to a frame already in progress, which then produces no strobe.
- R2: A frame is one low start bit, eight data bits with bit 0 sent first, and one high stop bit, each bit 16 ticks long. The byte given on the output after the strobe equals the eight data bits in that order.
- R3: The strobe is high for exactly one clock cycle per frame. The output byte changes only in the cycle the strobe is raised and holds its value until the next strobe.
- R4: The stop bit is sampled 16 ticks after the last data bit. If it is low, the framing flag is high in the same cycle as the strobe, and the byte is still delivered. If it is high, the flag stays low.
- R5: If the line is high again when it is sampled 8 ticks after the falling edge, the receiver returns to idle. There is no strobe and the output byte is unchanged.
- R6: A start bit is accepted only after the line has been seen high since reset or since the end of the previous frame. A line held low produces no frame.
- R7: A new start bit that begins right at the end of the previous stop bit, with no idle time between, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Clock enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| byte_out | output | 8 | Last received byte |
| byte_vld | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Stop bit was low; valid only with the strobe |

## Verification
The delivery of the byte and the stop-bit judgement happen in the same clock cycle. The strobe, the byte and the framing flag are therefore compared together, as a single expected entry taken from a queue. To provoke the case, one frame is sent with its stop bit held low. The bench expects both the strobe and the flag in that cycle, with the correct byte. It also expects the next frame to wait until the line has been high again.

// File: rtl/serial_rx_marker.sv
module serial_rx_marker #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rxd,
  output logic [DW-1:0] byte_out,
  output logic          byte_vld,
  output logic          frame_err
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] MID  = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_RUN} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [PW-1:0] phase;
  logic [DW:0]   shreg;
  logic          armed;
  logic          rx;

  assign rx = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync      <= 2'b11;
      st        <= S_IDLE;
      phase     <= '0;
      shreg     <= '1;
      armed     <= 1'b0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      sync      <= {sync[0], rxd};
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (tick16) begin
        case (st)
          S_IDLE: begin
            if (rx) armed <= 1'b1;
            else if (armed) begin
              armed <= 1'b0;
              phase <= '0;
              shreg <= '1;
              st    <= S_START;
            end
          end
          S_START: begin
            if (phase == MID) begin
              phase <= '0;
              if (rx) st <= S_IDLE;
              else begin
                shreg <= {rx, shreg[DW:1]};
                st    <= S_RUN;
              end
            end else phase <= phase + 1'b1;
          end
          S_RUN: begin
            if (phase == LAST) begin
              phase <= '0;
              if (!shreg[0]) begin
                byte_out  <= shreg[DW:1];
                byte_vld  <= 1'b1;
                frame_err <= ~rx;
                shreg     <= '1;
                st        <= S_IDLE;
              end else shreg <= {rx, shreg[DW:1]};
            end else phase <= phase + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module serial_rx_marker_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] byte_out,
  input logic          byte_vld,
  input logic          frame_err
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!byte_vld && !frame_err && byte_out == '0));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  a_r3_byte_held: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |-> $stable(byte_out));

  a_r4_flag_with_strobe: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> byte_vld);
endmodule

bind serial_rx_marker serial_rx_marker_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .byte_out(byte_out),
  .byte_vld(byte_vld), .frame_err(frame_err)
);

// File: tb/serial_rx_marker_tb.sv
module serial_rx_marker_tb;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b0;
  logic [7:0] byte_out;
  logic       byte_vld;
  logic       frame_err;

  int total = 0;
  int bad = 0;
  int unexpected = 0;
  bit finished = 0;
  logic [8:0] expq[$];
  logic prev_vld = 1'b0;

  serial_rx_marker u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .byte_out(byte_out), .byte_vld(byte_vld), .frame_err(frame_err)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic stop_ok);
    expq.push_back({~stop_ok, d});
    hold(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold(d[i], BITCLK);
    hold(stop_ok, BITCLK);
  endtask

  // monitor: R2 byte, R4 flag, R3 pulse width, R5/R6 no spurious strobe
  always @(negedge clk) begin
    if (!rst && byte_vld) begin
      if (prev_vld) check(1'b0, "R3 strobe longer than one cycle", 1, 0);
      else if (expq.size() == 0) begin
        unexpected++;
        check(1'b0, "R5 R6 strobe without a frame", byte_out, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(byte_out == e[7:0], "R2 received byte", byte_out, e[7:0]);
        check(frame_err == e[8], "R4 framing flag", frame_err, e[8]);
      end
    end
    prev_vld = byte_vld;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(byte_out == 8'h00 && !byte_vld && !frame_err, "R1 reset state",
          {byte_vld, frame_err, byte_out}, 0);
    rst = 1'b0;
    hold(1'b0, 400);
    check(unexpected == 0, "R6 low line gives no frame", unexpected, 0);
    hold(1'b1, 100);

    send_byte(8'h55, 1'b1); hold(1'b1, 80);
    send_byte(8'hA3, 1'b1); hold(1'b1, 80);
    send_byte(8'h00, 1'b1); hold(1'b1, 80);
    send_byte(8'hFF, 1'b1); hold(1'b1, 80);
    send_byte(8'h80, 1'b1); hold(1'b1, 80);
    check(byte_out == 8'h80, "R3 byte held in idle", byte_out, 8'h80);

    // R4: low stop bit, then line stays low: R6 no restart
    send_byte(8'h3C, 1'b0);
    hold(1'b0, 200);
    check(unexpected == 0, "R6 no restart after low stop", unexpected, 0);
    hold(1'b1, 100);

    // R5: glitch of 12 clocks (3 ticks)
    hold(1'b0, 12);
    hold(1'b1, 300);
    check(unexpected == 0, "R5 glitch gives no strobe", unexpected, 0);
    check(byte_out == 8'h3C, "R5 byte unchanged after glitch", byte_out, 8'h3C);

    // R7: back to back frames
    send_byte(8'h01, 1'b1);
    send_byte(8'hC7, 1'b1);
    send_byte(8'h5A, 1'b1);
    hold(1'b1, 100);
    check(byte_out == 8'h5A, "R7 last back-to-back byte", byte_out, 8'h5A);

    // R1: reset in the middle of a frame
    hold(1'b0, BITCLK);
    hold(1'b1, BITCLK);
    hold(1'b0, BITCLK);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(byte_out == 8'h00 && !byte_vld, "R1 reset mid-frame", byte_out, 0);
    rst = 1'b0;
    hold(1'b0, 5 * BITCLK);
    hold(1'b1, 200);
    check(unexpected == 0, "R1 aborted frame gives no strobe", unexpected, 0);

    send_byte(8'h96, 1'b1); hold(1'b1, 100);
    check(expq.size() == 0, "R2 every frame delivered", expq.size(), 0);
    finish_run();
  end
endmodule